// File: doc/BRIEF.md
# Interrupt Controller Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software sets a prescaler through a divide register and loads an initial count. The timer then counts down once per prescaled tick. When it expires it raises a one-cycle interrupt request that carries the 8-bit vector held in the timer's vector entry. The entry also picks one-shot or periodic operation and can mask the request.

Software reaches four 32-bit registers through a single select field. Writes happen on the clock edge where `wr_en` is high, and the read data follows the select field combinationally. The request leaves the block on a valid pulse with its vector alongside. It is edge-triggered, with fixed delivery.

Top module: `intc_timer`

## Requirements
- R1: After reset the vector entry reads 0x0001_0000 (masked, one-shot, vector 0). The initial count, current count and divide register read 0, and `irq_valid` is low.
- R2: The divide register (select 3) keeps only write bits 3, 1 and 0. Every other bit reads as 0.
- R3: The 3-bit code is {bit3, bit1, bit0}. The timer ticks once every 2^((code+1) mod 8) clocks, so code 7 divides by 1 and code 0 divides by 2.
- R4: A write to the initial count (select 1) loads the current count with the written value and restarts the prescaler. After the write edge, the k-th tick falls k·D clocks later, where D is the divide ratio.
- R5: In one-shot mode the current count drops by one per tick and stays at 0. Exactly one request is raised (N+1)·D clocks after an initial-count write of N≠0. An initial count of 0 raises no request.
- R6: In periodic mode (entry bit 17 = 1) a request is raised every (N+1)·D clocks, and the current count reads N − (ticks mod (N+1)). With N = 0 no request is ever raised.
- R7: While entry bit 16 (mask) is 1, expiries raise no request, but the count still advances.
- R8: A request is a single-cycle `irq_valid` pulse. `irq_vector` carries entry bits 7:0 as they were at the expiry edge.
- R9: Select 2 reads the live current count. Writes to select 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 entry, 1 initial count, 2 current count, 3 divide |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_sel` |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
A wrong prescaler code or shift shows up at once on the current-count read. The first decrement lands at the wrong clock, and that is within D clocks of a load. A wrong reload or a lost arming state in the counter shows up at the first expiry: the request arrives off by whole ticks, arrives twice, or never arrives. The sweep measures the exact clock distance from each load to each request, for every divide code in both modes.

// File: rtl/intc_timer_pkg.sv
// Shared constants for the interrupt controller timer.
// Assumes a 32-bit register port with a 2-bit select.
package intc_timer_pkg;
    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_CUR   = 2'd2,
        SEL_DIV   = 2'd3
    } tmr_sel_e;

    localparam int ENTRY_PERIODIC_BIT = 17;
    localparam int ENTRY_MASK_BIT     = 16;
    localparam logic [3:0] DIV_KEEP   = 4'hB;
endpackage

// File: rtl/tmr_prescale.sv
// Prescaler: emits a tick every 2^((code+1) mod 8) clocks.
// Assumes restart clears the phase so the first tick comes a full period later.
module tmr_prescale #(
    parameter int SHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic [SHW-1:0] code,
    output logic           tick
);
    localparam int PCW = (1 << SHW) - 1;

    logic [SHW-1:0] shift;
    logic [PCW-1:0] phase;
    logic [PCW-1:0] mask;

    // Shift amount and the phase mask that goes with it.
    always_comb begin
        shift = code + 1'b1;
        mask  = PCW'((1 << shift) - 1);
        tick  = (phase & mask) == mask;
    end

    // Free-running phase counter, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase <= '0;
        else                   phase <= phase + 1'b1;
    end
endmodule

// File: rtl/tmr_count.sv
// Down counter: decrements on ticks, saturates or reloads at zero,
// and flags expiry. A load overrides a tick in the same cycle.
module tmr_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    input  logic          tick,
    input  logic          periodic,
    output logic [CW-1:0] cur,
    output logic          expire
);
    logic armed;
    logic at_zero;

    // Expiry decision for this cycle's tick.
    always_comb begin
        at_zero = (cur == '0);
        expire  = tick && !load && at_zero &&
                  (periodic ? (reload_val != '0) : armed);
    end

    // Counter and one-shot arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cur   <= load_val;
            armed <= (load_val != '0);
        end else if (tick) begin
            if (!at_zero)      cur <= cur - 1'b1;
            else if (periodic) cur <= reload_val;
            if (at_zero && !periodic) armed <= 1'b0;
        end
    end

    AST_ONESHOT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && !load && tick && at_zero) |=> (cur == '0)); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cur != '0) |=> (cur == $past(cur) || cur == $past(cur) - 1'b1)); // R4
    AST_PERIODIC_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic && reload_val == '0) |-> !expire); // R6
endmodule

// File: rtl/intc_timer.sv
// Interrupt controller countdown timer: register port, prescaler,
// counter and request output. Assumes a single writer and no bus decode.
module intc_timer
    import intc_timer_pkg::*;
#(
    parameter int DW  = 32,
    parameter int VW  = 8,
    parameter int SHW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq_valid,
    output logic [VW-1:0] irq_vector
);
    logic [VW-1:0] vec_q;
    logic          mask_q;
    logic          periodic_q;
    logic [DW-1:0] init_q;
    logic [3:0]    div_q;
    logic          load;
    logic          tick;
    logic          expire;
    logic [DW-1:0] cur;
    logic [SHW-1:0] code;

    assign load = wr_en && (reg_sel == SEL_INIT);
    assign code = {div_q[3], div_q[1], div_q[0]};

    // Register writes; the current-count select is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q      <= '0;
            mask_q     <= 1'b1;
            periodic_q <= 1'b0;
            init_q     <= '0;
            div_q      <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                SEL_ENTRY: begin
                    vec_q      <= wr_data[VW-1:0];
                    mask_q     <= wr_data[ENTRY_MASK_BIT];
                    periodic_q <= wr_data[ENTRY_PERIODIC_BIT];
                end
                SEL_INIT: init_q <= wr_data;
                SEL_DIV:  div_q  <= wr_data[3:0] & DIV_KEEP;
                default:  ;
            endcase
        end
    end

    // Read mux for the register port.
    always_comb begin
        rd_data = '0;
        unique case (reg_sel)
            SEL_ENTRY: begin
                rd_data[VW-1:0]           = vec_q;
                rd_data[ENTRY_MASK_BIT]     = mask_q;
                rd_data[ENTRY_PERIODIC_BIT] = periodic_q;
            end
            SEL_INIT: rd_data = init_q;
            SEL_CUR:  rd_data = cur;
            SEL_DIV:  rd_data[3:0] = div_q;
            default:  ;
        endcase
    end

    tmr_prescale #(.SHW(SHW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .code    (code),
        .tick    (tick)
    );

    tmr_count #(.CW(DW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (wr_data),
        .reload_val (init_q),
        .tick       (tick),
        .periodic   (periodic_q),
        .cur        (cur),
        .expire     (expire)
    );

    // Request register: a pulse on an unmasked expiry, carrying the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= expire && !mask_q;
            if (expire) irq_vector <= vec_q;
        end
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(mask_q)); // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid); // R8
    AST_DIV_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q & ~DIV_KEEP) == 4'h0); // R2
endmodule

// File: tb/tb_intc_timer.sv
module tb_intc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    intc_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; reg_sel = 2'd2;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = rd_data;
        reg_sel = 2'd2;
    endtask

    function automatic logic [31:0] div_word(input int c);
        return {28'd0, c[2], 1'b0, c[1], c[0]};
    endfunction

    // Load N and follow the count and requests for `span` clocks.
    task automatic run_case(input int c, input int n, input bit per, input bit msk,
                            input logic [7:0] vec, input int span, input string req);
        int d = 1 << ((c + 1) % 8);
        int fires = 0;
        int bad_cnt = 0;
        int bad_irq = 0;
        logic [31:0] exp_cur, got;
        wr(2'd3, div_word(c));
        wr(2'd0, {14'd0, per, msk, 8'd0, vec});
        wr(2'd1, n);
        for (int m = 1; m <= span; m++) begin
            int t;
            @(negedge clk);
            t = m / d;
            if (per) exp_cur = n - (t % (n + 1));
            else     exp_cur = (t >= n) ? 0 : n - t;
            got = rd_data;
            if (got !== exp_cur && bad_cnt == 0) begin
                bad_cnt = 1;
                check({req, " count"}, got, exp_cur);
            end
            if (irq_valid) begin
                bit due;
                fires++;
                due = (n != 0) && !msk && (m % ((n + 1) * d) == 0) && (per || m == (n + 1) * d);
                if ((!due || irq_vector !== vec) && bad_irq == 0) begin
                    bad_irq = 1;
                    check({req, " irq time/vector R8"}, {m[23:0], irq_vector}, {m[23:0], vec} ^ 32'h1);
                end
            end
        end
        if (bad_cnt == 0) check({req, " count"}, 1, 1);
        if (bad_irq == 0) check({req, " irq time/vector R8"}, 1, 1);
        begin
            int exp_f;
            if (n == 0 || msk) exp_f = 0;
            else if (per) exp_f = span / ((n + 1) * d);
            else exp_f = (span >= (n + 1) * d) ? 1 : 0;
            check({req, " irq count"}, fires, exp_f);
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++; n_checks++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 entry", v, 32'h0001_0000);
        rd(2'd1, v); check("R1 init", v, 0);
        rd(2'd2, v); check("R1 cur", v, 0);
        rd(2'd3, v); check("R1 div", v, 0);
        check("R1 irq", irq_valid, 0);
        // R2 divide masking
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); check("R2 div keep", v, 32'hB);
        wr(2'd3, 32'h0000_0004); rd(2'd3, v); check("R2 div drop", v, 32'h0);
        // R3/R4/R5 one-shot sweep over every divide code
        for (int c = 0; c < 8; c++) begin
            int d = 1 << ((c + 1) % 8);
            run_case(c, 2, 1'b0, 1'b0, 8'h30 + 8'(c), 5 * d, "R3 R4 R5 oneshot");
        end
        // R6 periodic sweep
        for (int c = 0; c < 8; c++) begin
            int d = 1 << ((c + 1) % 8);
            run_case(c, 1, 1'b1, 1'b0, 8'h50 + 8'(c), 6 * d + 1, "R3 R6 periodic");
        end
        run_case(7, 4, 1'b1, 1'b0, 8'hA5, 23, "R6 periodic N4");
        // R5 / R6 zero count never fires
        run_case(7, 0, 1'b0, 1'b0, 8'h11, 20, "R5 zero oneshot");
        run_case(0, 0, 1'b1, 1'b0, 8'h12, 20, "R6 zero periodic");
        // R7 masked: counting continues, no request
        run_case(7, 3, 1'b0, 1'b1, 8'h22, 20, "R7 masked oneshot");
        run_case(7, 2, 1'b1, 1'b1, 8'h23, 20, "R7 masked periodic");
        // R4 reload mid-count restarts from new value
        run_case(7, 9, 1'b0, 1'b0, 8'h44, 4, "R4 partial");
        run_case(7, 3, 1'b0, 1'b0, 8'h45, 8, "R4 reload");
        // R9 writes to current count ignored
        wr(2'd3, div_word(6));
        wr(2'd1, 32'd50);
        wr(2'd2, 32'd7);
        rd(2'd2, v); check("R9 cur write ignored", v, 32'd50);
        rd(2'd1, v); check("R9 init unchanged", v, 32'd50);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule